// File: doc/BRIEF.md
# Node Identifier and Schedule Programming Receiver

Each node of a distributed electrode array carries one copy of this block. All copies run the same logic. A node takes its identity only from a node identifier register. That register is loaded at power-up from a daisy-chained program line. Bits shifted past the most significant position leave on a pass-through output and feed the next node in the chain.

Once the identifiers are in place, the host broadcasts byte packets on a shared address line. Each packet holds two bytes: a select byte that names one node, then a command byte. The command byte says whether a schedule slot records or stimulates, and which of six electrodes it uses.

The node whose identifier matches the select byte answers with an acknowledge byte on its serial return output. If the command is legal, it answers with a second acknowledge and queues the command in its ten-slot schedule FIFO. Every other node queues a no-operation slot at the same moment. As a result, all schedules in the array stay aligned slot for slot. A node that does not answer can be treated as failed by the host.

All serial inputs are sampled as single-cycle strobes in the block clock domain.

Top module: `node_sched_rx`

## Requirements
- R1: After reset the schedule is empty: `sched_count`=0, `sched_empty`=1, `sched_full`=0 and `sched_ovf`=0. The return line is idle: `ack_busy`=0 and `ack_dout`=0. The identifier register is zero.
- R2: On each `prog_shift` strobe, `prog_din` enters the identifier register at bit 0 and the register moves up one place. `prog_dout` always shows the register's most significant bit. A node therefore passes the previous identifier on, most significant bit first, while it loads a new one.
- R3: Address bits arrive most significant bit first, one per `addr_shift` strobe. Every eighth strobe completes a byte. Bytes alternate in role: select byte, then command byte, starting with a select byte after reset.
- R4: A select byte equal to the node identifier makes the node send the acknowledge byte 0xA5 on `ack_dout`. The byte goes out most significant bit first, one bit per clock, while `ack_busy` is high for exactly 8 cycles. The first bit appears two clock edges after the edge that sampled the byte's last strobe. A non-matching select byte leaves `ack_busy` low.
- R5: The command byte uses bit 7 as the action (1 = stimulate, 0 = record) and bits 2:0 as the electrode index. Bits 6:3 are ignored. On a selected node, an index from 0 to 5 queues the slot {nop=0, stim, electrode} and sends a second 0xA5 with the timing of R4. The slot read from `sched_slot` packs nop in bit 4, stim in bit 3 and the electrode in bits 2:0.
- R6: On a selected node, a command byte whose electrode index is 6 or 7 is rejected. No acknowledge is sent, and a no-operation slot (5'b10000) is queued instead.
- R7: A node not named by the select byte sends no acknowledge for either byte. It queues the no-operation slot 5'b10000 when the command byte completes.
- R8: The schedule holds 10 slots in arrival order, and `sched_slot` shows the oldest one. A `sched_rd` pulse removes it. A read when empty has no effect. `sched_count` is updated two edges after the last command bit's strobe edge.
- R9: A slot written while the schedule is full is dropped: count and contents are unchanged. The write also sets `sched_ovf`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_din | input | 1 | Serial identifier data from the previous node |
| prog_shift | input | 1 | Identifier shift strobe |
| prog_dout | output | 1 | Identifier bit passed to the next node |
| addr_din | input | 1 | Broadcast packet data |
| addr_shift | input | 1 | Packet bit strobe |
| ack_dout | output | 1 | Serial acknowledge return |
| ack_busy | output | 1 | High while an acknowledge byte is being sent |
| sched_rd | input | 1 | Pop the oldest schedule slot |
| sched_slot | output | 5 | Oldest slot: {nop, stim, electrode[2:0]} |
| sched_empty | output | 1 | Schedule holds no slot |
| sched_full | output | 1 | Schedule holds 10 slots |
| sched_count | output | 4 | Number of queued slots |
| sched_ovf | output | 1 | Sticky overflow flag |

## Verification
The strobe that carries a byte's last bit is sampled on one edge. The byte is assembled by that edge, and the next edge both loads the acknowledge and writes the schedule. So `ack_busy`, the first acknowledge bit and the new `sched_count` are all due at the falling edge that follows the second rising edge. The bench samples there and then follows each of the 8 acknowledge bits on successive falling edges. `prog_dout` and `sched_slot` come straight from registers, so they are checked on the falling edge after the strobe or pop edge that changed them.

// File: rtl/ns_pkg.sv
package ns_pkg;
  localparam int BYTE_W     = 8;
  localparam int ELEC_COUNT = 6;
  localparam logic [BYTE_W-1:0] ACK_CODE = 8'hA5;

  typedef struct packed {
    logic       nop;
    logic       stim;
    logic [2:0] elec;
  } slot_t;

  typedef enum logic {PH_SELECT = 1'b0, PH_COMMAND = 1'b1} phase_t;

  // Command is legal when its electrode index names an existing electrode
  function automatic logic cmd_legal(input logic [BYTE_W-1:0] cmd);
    return int'(cmd[2:0]) < ELEC_COUNT;
  endfunction

  function automatic slot_t cmd_slot(input logic [BYTE_W-1:0] cmd);
    slot_t s;
    s.nop  = 1'b0;
    s.stim = cmd[7];
    s.elec = cmd[2:0];
    return s;
  endfunction

  function automatic slot_t idle_slot();
    slot_t s;
    s.nop  = 1'b1;
    s.stim = 1'b0;
    s.elec = 3'd0;
    return s;
  endfunction
endpackage

// File: rtl/ns_id_chain.sv
module ns_id_chain #(
  parameter int ID_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shift_en,
  input  logic            din,
  output logic            dout,
  output logic [ID_W-1:0] id
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      id <= '0;
    end else if (shift_en) begin
      id <= {id[ID_W-2:0], din};
    end
  end

  assign dout = id[ID_W-1];
endmodule

// File: rtl/ns_byte_rx.sv
module ns_byte_rx #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              din,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_data
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic [CNT_W-1:0] bit_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byte_data  <= '0;
      bit_cnt    <= '0;
      byte_valid <= 1'b0;
    end else if (shift_en) begin
      byte_data  <= {byte_data[BYTE_W-2:0], din};
      bit_cnt    <= (bit_cnt == CNT_W'(BYTE_W - 1)) ? '0 : bit_cnt + 1'b1;
      byte_valid <= (bit_cnt == CNT_W'(BYTE_W - 1));
    end else begin
      byte_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ns_ack_tx.sv
module ns_ack_tx #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] data,
  output logic              busy,
  output logic              dout
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic [BYTE_W-1:0] sr;
  logic [CNT_W-1:0]  cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr   <= '0;
      cnt  <= '0;
      busy <= 1'b0;
    end else if (load) begin
      sr   <= data;
      cnt  <= '0;
      busy <= 1'b1;
    end else if (busy) begin
      sr <= {sr[BYTE_W-2:0], 1'b0};
      if (cnt == CNT_W'(BYTE_W - 1)) begin
        busy <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign dout = busy & sr[BYTE_W-1];
endmodule

// File: rtl/ns_sched_fifo.sv
module ns_sched_fifo #(
  parameter int DEPTH = 10,
  parameter int WIDTH = 5,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full,
  output logic             ovf
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic             do_wr, do_rd;

  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));
  assign do_wr = wr_en & ~full;
  assign do_rd = rd_en & ~empty;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_wr) begin
      mem[wp] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      if (do_wr) wp <= ptr_next(wp);
      if (do_rd) rp <= ptr_next(rp);
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (wr_en && full) ovf <= 1'b1;
    end
  end

  assign rd_data = empty ? '0 : mem[rp];
endmodule

// File: rtl/node_sched_rx.sv
module node_sched_rx #(
  parameter int ID_W  = 8,
  parameter int DEPTH = 10,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog_din,
  input  logic             prog_shift,
  output logic             prog_dout,
  input  logic             addr_din,
  input  logic             addr_shift,
  output logic             ack_dout,
  output logic             ack_busy,
  input  logic             sched_rd,
  output logic [4:0]       sched_slot,
  output logic             sched_empty,
  output logic             sched_full,
  output logic [CNT_W-1:0] sched_count,
  output logic             sched_ovf
);
  import ns_pkg::*;

  logic [ID_W-1:0]   node_id;
  logic              byte_valid;
  logic [BYTE_W-1:0] rx_byte;
  phase_t            phase;
  logic              sel_hit;
  logic              id_match;
  logic              ack_load;
  logic              wr_evt;
  slot_t             wr_slot;

  ns_id_chain #(.ID_W(ID_W)) u_chain (
    .clk(clk), .rst_n(rst_n), .shift_en(prog_shift),
    .din(prog_din), .dout(prog_dout), .id(node_id)
  );

  ns_byte_rx #(.BYTE_W(BYTE_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .shift_en(addr_shift),
    .din(addr_din), .byte_valid(byte_valid), .byte_data(rx_byte)
  );

  assign id_match = (rx_byte == BYTE_W'(node_id));

  // Packet decoder: select byte then command byte
  always_comb begin
    ack_load = 1'b0;
    wr_evt   = 1'b0;
    wr_slot  = idle_slot();
    if (byte_valid) begin
      if (phase == PH_SELECT) begin
        ack_load = id_match;
      end else begin
        wr_evt = 1'b1;
        if (sel_hit && cmd_legal(rx_byte)) begin
          wr_slot  = cmd_slot(rx_byte);
          ack_load = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_SELECT;
      sel_hit <= 1'b0;
    end else if (byte_valid) begin
      if (phase == PH_SELECT) begin
        phase   <= PH_COMMAND;
        sel_hit <= id_match;
      end else begin
        phase   <= PH_SELECT;
        sel_hit <= 1'b0;
      end
    end
  end

  ns_ack_tx #(.BYTE_W(BYTE_W)) u_ack (
    .clk(clk), .rst_n(rst_n), .load(ack_load), .data(ACK_CODE),
    .busy(ack_busy), .dout(ack_dout)
  );

  ns_sched_fifo #(.DEPTH(DEPTH), .WIDTH($bits(slot_t))) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_evt), .wr_data(wr_slot),
    .rd_en(sched_rd), .rd_data(sched_slot), .count(sched_count),
    .empty(sched_empty), .full(sched_full), .ovf(sched_ovf)
  );
endmodule

// File: rtl/node_sched_rx_chk.sv
module node_sched_rx_chk #(
  parameter int ID_W  = 8,
  parameter int DEPTH = 10,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             prog_shift,
  input logic             prog_din,
  input logic [ID_W-1:0]  node_id,
  input logic             byte_valid,
  input logic             wr_evt,
  input logic             ack_busy,
  input logic             sched_rd,
  input logic             sched_empty,
  input logic             sched_full,
  input logic [CNT_W-1:0] sched_count,
  input logic             sched_ovf
);
  // R2
  id_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_shift |=> node_id[0] == $past(prog_din));

  // R4
  ack_follows_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_busy) |-> $past(byte_valid));

  // R8
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sched_count <= CNT_W'(DEPTH));

  // R8
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sched_rd && sched_empty && !wr_evt) |=> sched_count == '0);

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && sched_full && !sched_rd) |=> $stable(sched_count) && sched_ovf);

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sched_ovf |=> sched_ovf);
endmodule

bind node_sched_rx node_sched_rx_chk #(.ID_W(ID_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .prog_shift(prog_shift), .prog_din(prog_din),
  .node_id(node_id), .byte_valid(byte_valid), .wr_evt(wr_evt),
  .ack_busy(ack_busy), .sched_rd(sched_rd), .sched_empty(sched_empty),
  .sched_full(sched_full), .sched_count(sched_count), .sched_ovf(sched_ovf)
);

// File: tb/node_sched_rx_tb_top.sv
`timescale 1ns/1ps
module node_sched_rx_tb_top;
  localparam int ID_W  = 8;
  localparam int DEPTH = 10;
  localparam logic [7:0] ACKB = 8'hA5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       prog_din = 1'b0, prog_shift = 1'b0, prog_dout;
  logic       addr_din = 1'b0, addr_shift = 1'b0;
  logic       ack_dout, ack_busy;
  logic       sched_rd = 1'b0;
  logic [4:0] sched_slot;
  logic       sched_empty, sched_full, sched_ovf;
  logic [3:0] sched_count;

  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;
  logic [7:0] my_id;
  logic [4:0] expq[$];

  always #2.5 clk = ~clk;

  node_sched_rx #(.ID_W(ID_W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .prog_din(prog_din), .prog_shift(prog_shift),
    .prog_dout(prog_dout), .addr_din(addr_din), .addr_shift(addr_shift),
    .ack_dout(ack_dout), .ack_busy(ack_busy), .sched_rd(sched_rd),
    .sched_slot(sched_slot), .sched_empty(sched_empty), .sched_full(sched_full),
    .sched_count(sched_count), .sched_ovf(sched_ovf)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Slot the schedule should hold after a command, from R5/R6/R7
  function automatic logic [4:0] model_slot(input logic hit, input logic [7:0] cmd);
    if (hit && cmd[2:0] <= 3'd5) return {1'b0, cmd[7], cmd[2:0]};
    return 5'b10000;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    expq.delete();
  endtask

  task automatic load_id(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); prog_din = v[i]; prog_shift = 1'b1;
    end
    @(negedge clk); prog_shift = 1'b0;
    my_id = v;
  endtask

  // Sends a byte, then follows the 8 cycles where the acknowledge is due
  task automatic send_byte(input logic [7:0] b, input logic want_ack, input string req);
    logic [7:0] got;
    logic       busy_ok;
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); addr_din = b[i]; addr_shift = 1'b1;
    end
    @(negedge clk); addr_shift = 1'b0;
    busy_ok = 1'b1;
    got = '0;
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk);
      got[i] = ack_dout;
      if (ack_busy !== want_ack) busy_ok = 1'b0;
    end
    @(negedge clk);
    if (ack_busy !== 1'b0) busy_ok = 1'b0;
    check({req, " ack busy window"}, {31'd0, busy_ok}, 32'd1);
    check({req, " ack byte"}, {24'd0, got}, want_ack ? {24'd0, ACKB} : 32'd0);
  endtask

  task automatic send_packet(input logic [7:0] sel, input logic [7:0] cmd, input string req);
    logic hit;
    hit = (sel == my_id);
    send_byte(sel, hit, hit ? "R4" : "R7");
    send_byte(cmd, hit && cmd[2:0] <= 3'd5, req);
    if (expq.size() < DEPTH) expq.push_back(model_slot(hit, cmd));
    check({req, " count"}, {28'd0, sched_count}, expq.size());
  endtask

  task automatic drain(input string req);
    while (expq.size() > 0) begin
      @(negedge clk);
      check({req, " slot"}, {27'd0, sched_slot}, {27'd0, expq[0]});
      void'(expq.pop_front());
      sched_rd = 1'b1;
      @(negedge clk); sched_rd = 1'b0;
    end
    check({req, " empty after drain"}, {31'd0, sched_empty}, 32'd1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] sel, cmd;
    void'($urandom(32'd4242));
    do_reset();
    @(negedge clk);
    // R1
    check("R1 count", {28'd0, sched_count}, 0);
    check("R1 empty/full/ovf", {29'd0, sched_empty, sched_full, sched_ovf}, 32'b100);
    check("R1 ack idle", {30'd0, ack_busy, ack_dout}, 0);
    check("R1 id zero", {31'd0, prog_dout}, 0);

    // R2: load one id, then watch it leave while a new one enters
    load_id(8'h3C);
    for (int i = 7; i >= 0; i--) begin
      check("R2 pass-through", {31'd0, prog_dout}, {31'd0, my_id[i]});
      prog_din = 1'(8'h5A >> i); prog_shift = 1'b1;
      @(negedge clk);
    end
    prog_shift = 1'b0;
    my_id = 8'h5A;
    check("R2 new id msb", {31'd0, prog_dout}, 0);

    // R3/R4/R5 directed: old id no longer selects, new one does
    send_packet(8'h3C, 8'h01, "R3 stale id");
    send_packet(8'h5A, 8'h85, "R5 stim e5");
    send_packet(8'h5A, 8'h78, "R5 record e0 upper bits ignored");
    send_packet(8'h5A, 8'h06, "R6 electrode 6");
    send_packet(8'h5A, 8'h87, "R6 electrode 7");
    drain("R8 directed");

    // R8: read while empty has no effect
    @(negedge clk); sched_rd = 1'b1;
    @(negedge clk); sched_rd = 1'b0;
    check("R8 empty read count", {28'd0, sched_count}, 0);

    // Random packets, drained every three
    for (int g = 0; g < 8; g++) begin
      for (int p = 0; p < 3; p++) begin
        sel = ($urandom % 2) ? my_id : 8'($urandom);
        cmd = 8'($urandom);
        send_packet(sel, cmd, "R5/R6/R7 random");
      end
      drain("R8 random");
    end

    // R9: overflow
    for (int k = 0; k < DEPTH; k++) send_packet(my_id, 8'(k % 6), "R8 fill");
    check("R8 full", {31'd0, sched_full}, 1);
    send_packet(my_id, 8'h82, "R9 write when full");
    check("R9 count held", {28'd0, sched_count}, DEPTH);
    check("R9 ovf set", {31'd0, sched_ovf}, 1);
    drain("R9 contents kept");
    check("R9 ovf sticky", {31'd0, sched_ovf}, 1);
    do_reset();
    @(negedge clk);
    check("R9 ovf cleared by reset", {31'd0, sched_ovf}, 0);
    check("R1 id cleared", {31'd0, prog_dout}, 0);
    my_id = 8'h00;
    send_packet(8'h00, 8'h03, "R5 after reset id 0");
    drain("R8 final");
    finish_run();
  end
endmodule